// File: doc/BRIEF.md
# Timer Channel Control Register Bank

This block is the register front end of an eight-channel timer. The block decodes a 32-bit register bus address into a channel index and an offset within that channel's 64-byte window. It forwards accesses to the counting registers (count, reload and two match values) to a per-channel counter port. It holds four control flags and one interrupt status flag for every channel.

The control flags never take a whole-word write. A "set" register turns on the flags whose data bits are 1. A "clear" register turns off the flags whose data bits are 1. When enable changes in the same write as the other flags, the bank orders the update. On a set, configuration lands first and enable follows one cycle later. On a clear, enable drops first and configuration clears one cycle later. This keeps a counter from ever running with a half-written configuration.

Interrupt status is raised by the counters through a per-channel event input. Software clears it through a dedicated bit of the clear register. Every bus access is accepted in the cycle it is presented, and read data returns one cycle later.

Top module: `tmr_ctl_bank`

## Requirements
- R1: The channel index is address bits [8:6] and the window offset is bits [5:0]. An access whose address bits [31:9] are not all zero is ignored on write and returns zero on read.
- R2: A write to offset 0x00, 0x04, 0x08 or 0x0C (count, reload, first match, second match) is forwarded to the counter port on the next cycle. The forwarded access carries a one-hot write strobe for the addressed channel, the register select `offset[3:2]` and the write data. At most one strobe bit is ever high.
- R3: A read of offset 0x00, 0x04, 0x08 or 0x0C drives the counter read port in the same cycle, with the channel on `ctr_rd_ch` and `offset[3:2]` on `ctr_rd_reg`. The value from `ctr_rdata` is returned on `bus_rdata` one cycle later.
- R4: A write to offset 0x10 without bit 0 sets each of flags [3:1] whose data bit is 1, one cycle after the write. Flags written as 0 keep their value. The flag order is enable (bit 0), external clock (bit 1), overflow interrupt (bit 2), pulse mode (bit 3).
- R5: A write to offset 0x10 with bit 0 set applies its flags [3:1] one cycle after the write and sets enable one cycle after that.
- R6: A write to offset 0x14 without bit 0 clears each of flags [3:1] whose data bit is 1, one cycle after the write. Flags written as 0 keep their value.
- R7: A write to offset 0x14 with bit 0 set clears enable one cycle after the write and clears its flags [3:1] one cycle after that. When a deferred step and a new write to the same channel meet in one cycle, the deferred step applies first.
- R8: A read of offset 0x10 returns the channel's four flags in bits [3:0] and its interrupt status in bit 16. All other bits read zero.
- R9: A read of offset 0x14, or of any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10, returns zero. Writes to offsets other than the six listed leave every output unchanged.
- R10: A high `ctr_event[i]` sets interrupt status i on the next cycle. A write to offset 0x14 with bit 16 set clears it. When the event and the clear arrive in the same cycle, the event wins.
- R11: A synchronous active-high reset clears all flags, all status bits, all pending deferred steps, the counter write strobe and `bus_rvalid`.
- R12: `bus_rvalid` is high exactly in the cycle after each read and low otherwise. No access is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| ctr_we | output | 8 | One-hot counter register write strobe per channel |
| ctr_reg | output | 2 | Counter register select for the write |
| ctr_wdata | output | 32 | Counter register write data |
| ctr_rd_ch | output | 3 | Channel addressed by the current read |
| ctr_rd_reg | output | 2 | Counter register addressed by the current read |
| ctr_rdata | input | 32 | Counter register value for `ctr_rd_ch`/`ctr_rd_reg` |
| ctr_event | input | 8 | Per-channel interrupt event from the counters |
| ch_ctrl | output | 32 | Four flags per channel, channel i in bits [4i+3:4i] |
| irq_status | output | 8 | Interrupt status per channel |

## Verification
The properties assume that `bus_wr` and `bus_rd` are never high in the same cycle, since the ordering and read checks are written for one access per cycle. The stimulus picks exactly one of write, read or idle in each cycle. The property on enable rising traces the rise back to a set write two cycles earlier. For that reason, the stimulus never changes enable in any other way after reset. Counter events are applied at random alongside writes that clear status, so the case where an event and a clear meet is covered.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;
  localparam int WIN_W = 6;   // byte window per channel
  localparam int CTL_W = 4;   // flags per channel
  localparam int EN_B  = 0;   // enable flag position
  localparam int STS_B = 16;  // status bit in the set/clear words
  localparam logic [WIN_W-1:0] OFF_SET = 6'h10;
  localparam logic [WIN_W-1:0] OFF_CLR = 6'h14;

  typedef enum logic [1:0] {K_NONE, K_CTR, K_SET, K_CLR} acc_kind_e;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_ctl_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int AW   = 32,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic [AW-1:0]   addr,
  output logic [CH_W-1:0] ch,
  output logic [1:0]      sel,
  output acc_kind_e       kind
);
  localparam int HI_LSB = WIN_W + CH_W;

  logic [WIN_W-1:0] off;
  logic             in_rng;

  always_comb begin
    off    = addr[WIN_W-1:0];
    ch     = addr[WIN_W +: CH_W];
    sel    = off[3:2];
    in_rng = (addr[AW-1:HI_LSB] == '0) && (int'(ch) < N_CH);
    kind   = K_NONE;
    if (in_rng) begin
      if (off[5:4] == 2'b00 && off[1:0] == 2'b00) kind = K_CTR;
      else if (off == OFF_SET)                    kind = K_SET;
      else if (off == OFF_CLR)                    kind = K_CLR;
    end
  end
endmodule

// File: rtl/tmr_chan_ctl.sv
module tmr_chan_ctl
  import tmr_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [CTL_W-1:0] wbits,
  input  logic             sts_clr,
  input  logic             evt,
  output logic [CTL_W-1:0] ctl,
  output logic             sts
);
  localparam logic [CTL_W-1:0] EN_MASK = CTL_W'(1 << EN_B);

  logic             pend_en;   // enable to assert next cycle
  logic [CTL_W-1:0] pend_cfg;  // config flags to clear next cycle
  logic [CTL_W-1:0] ctl_nx;
  logic             pend_en_nx;
  logic [CTL_W-1:0] pend_cfg_nx;

  always_comb begin
    // deferred step from the previous write goes first
    ctl_nx = ctl;
    if (pend_en) ctl_nx = ctl_nx | EN_MASK;
    ctl_nx      = ctl_nx & ~pend_cfg;
    pend_en_nx  = 1'b0;
    pend_cfg_nx = '0;
    if (set_stb) begin
      ctl_nx     = ctl_nx | (wbits & ~EN_MASK);
      pend_en_nx = wbits[EN_B];
    end
    if (clr_stb) begin
      if (wbits[EN_B]) begin
        ctl_nx      = ctl_nx & ~EN_MASK;
        pend_cfg_nx = wbits & ~EN_MASK;
      end else begin
        ctl_nx = ctl_nx & ~wbits;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      pend_en  <= 1'b0;
      pend_cfg <= '0;
      sts      <= 1'b0;
    end else begin
      ctl      <= ctl_nx;
      pend_en  <= pend_en_nx;
      pend_cfg <= pend_cfg_nx;
      sts      <= evt | (sts & ~sts_clr);
    end
  end
endmodule

// File: rtl/tmr_rd_path.sv
module tmr_rd_path
  import tmr_ctl_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int DW   = 32,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd,
  input  acc_kind_e             kind,
  input  logic [CH_W-1:0]       ch,
  input  logic [N_CH*CTL_W-1:0] ctl_all,
  input  logic [N_CH-1:0]       sts_all,
  input  logic [DW-1:0]         ctr_rdata,
  output logic [DW-1:0]         rdata,
  output logic                  rvalid
);
  logic [DW-1:0] val;

  always_comb begin
    val = '0;
    case (kind)
      K_CTR: val = ctr_rdata;
      K_SET: begin
        val[CTL_W-1:0] = ctl_all[int'(ch)*CTL_W +: CTL_W];
        val[STS_B]     = sts_all[ch];
      end
      default: val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? val : '0;
    end
  end
endmodule

// File: rtl/tmr_ctl_bank.sv
module tmr_ctl_bank
  import tmr_ctl_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic                  bus_rvalid,
  output logic [N_CH-1:0]       ctr_we,
  output logic [1:0]            ctr_reg,
  output logic [DW-1:0]         ctr_wdata,
  output logic [CH_W-1:0]       ctr_rd_ch,
  output logic [1:0]            ctr_rd_reg,
  input  logic [DW-1:0]         ctr_rdata,
  input  logic [N_CH-1:0]       ctr_event,
  output logic [N_CH*CTL_W-1:0] ch_ctrl,
  output logic [N_CH-1:0]       irq_status
);
  logic [CH_W-1:0] a_ch;
  logic [1:0]      a_sel;
  acc_kind_e       a_kind;

  tmr_addr_dec #(.N_CH(N_CH), .AW(AW)) u_dec (
    .addr (bus_addr),
    .ch   (a_ch),
    .sel  (a_sel),
    .kind (a_kind)
  );

  assign ctr_rd_ch  = a_ch;
  assign ctr_rd_reg = a_sel;

  // counter write port, one cycle after the bus write
  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_we    <= '0;
      ctr_reg   <= '0;
      ctr_wdata <= '0;
    end else begin
      ctr_we <= (bus_wr && a_kind == K_CTR) ? (N_CH'(1) << a_ch) : '0;
      if (bus_wr && a_kind == K_CTR) begin
        ctr_reg   <= a_sel;
        ctr_wdata <= bus_wdata;
      end
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic hit_ch;
    assign hit_ch = bus_wr && (a_ch == CH_W'(g));

    tmr_chan_ctl u_ch (
      .clk     (clk),
      .rst     (rst),
      .set_stb (hit_ch && a_kind == K_SET),
      .clr_stb (hit_ch && a_kind == K_CLR),
      .wbits   (bus_wdata[CTL_W-1:0]),
      .sts_clr (hit_ch && a_kind == K_CLR && bus_wdata[STS_B]),
      .evt     (ctr_event[g]),
      .ctl     (ch_ctrl[g*CTL_W +: CTL_W]),
      .sts     (irq_status[g])
    );
  end

  tmr_rd_path #(.N_CH(N_CH), .DW(DW)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd        (bus_rd),
    .kind      (a_kind),
    .ch        (a_ch),
    .ctl_all   (ch_ctrl),
    .sts_all   (irq_status),
    .ctr_rdata (ctr_rdata),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid)
  );
endmodule

// File: rtl/tmr_ctl_bank_chk.sv
module tmr_ctl_bank_chk #(
  parameter int N_CH = 8,
  parameter int AW   = 32,
  localparam int CH_W = $clog2(N_CH)
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [AW-1:0]       bus_addr,
  input logic                wbit0,
  input logic                bus_rvalid,
  input logic [N_CH-1:0]     ctr_we,
  input logic [N_CH-1:0]     ctr_event,
  input logic [N_CH*4-1:0]   ch_ctrl,
  input logic [N_CH-1:0]     irq_status
);
  localparam int HI_LSB = 6 + CH_W;

  // input assumption: one access per cycle (R12)
  a_r12_one_access: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));

  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> (ch_ctrl == '0 && irq_status == '0 && !bus_rvalid && ctr_we == '0));

  a_r12_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  a_r12_no_stray_rvalid: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  a_r2_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctr_we));

  a_r2_strobe_needs_write: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> ctr_we == '0);

  a_r1_high_addr_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[AW-1:HI_LSB] != '0) |=> ctr_we == '0);

  for (genvar i = 0; i < N_CH; i++) begin : g_p
    a_r10_event_sets: assert property (@(posedge clk) disable iff (rst)
      ctr_event[i] |=> irq_status[i]);

    a_r5_enable_last: assert property (@(posedge clk) disable iff (rst)
      $rose(ch_ctrl[i*4]) |-> ($past(bus_wr, 2) && $past(wbit0, 2) &&
        $past(bus_addr[5:0], 2) == 6'h10 &&
        $past(bus_addr[6 +: CH_W], 2) == CH_W'(i)));

    a_r7_disable_first: assert property (@(posedge clk) disable iff (rst)
      $fell(ch_ctrl[i*4]) |-> ($past(bus_wr) && $past(wbit0) &&
        $past(bus_addr[5:0]) == 6'h14 &&
        $past(bus_addr[6 +: CH_W]) == CH_W'(i)));
  end
endmodule

bind tmr_ctl_bank tmr_ctl_bank_chk #(.N_CH(N_CH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .wbit0      (bus_wdata[0]),
  .bus_rvalid (bus_rvalid),
  .ctr_we     (ctr_we),
  .ctr_event  (ctr_event),
  .ch_ctrl    (ch_ctrl),
  .irq_status (irq_status)
);

// File: tb/tb_tmr_ctl_bank.sv
module tb_tmr_ctl_bank;
  localparam int CLK_NS = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [N-1:0] ctr_we;
  logic [1:0]  ctr_reg;
  logic [31:0] ctr_wdata;
  logic [2:0]  ctr_rd_ch;
  logic [1:0]  ctr_rd_reg;
  logic [31:0] ctr_rdata;
  logic [N-1:0] ctr_event = '0;
  logic [4*N-1:0] ch_ctrl;
  logic [N-1:0] irq_status;

  int checks = 0;
  int fails  = 0;

  // bench model of the counters: a value that encodes channel and register
  assign ctr_rdata = 32'hC0DE_0000 | 32'({ctr_rd_ch, 2'b00, ctr_rd_reg});

  always #(CLK_NS/2) clk = ~clk;

  tmr_ctl_bank dut (.*);

  logic [3:0] m_ctl  [N];
  logic       m_pen  [N];
  logic [3:0] m_pcfg [N];
  logic       m_sts  [N];

  function automatic logic [31:0] ctr_val(int ch, logic [1:0] sel);
    return 32'hC0DE_0000 | (32'(ch) << 4) | 32'(sel);
  endfunction

  function automatic logic [4*N-1:0] pack_ctl();
    logic [4*N-1:0] v;
    for (int k = 0; k < N; k++) v[k*4 +: 4] = m_ctl[k];
    return v;
  endfunction

  function automatic logic [N-1:0] pack_sts();
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = m_sts[k];
    return v;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin
      m_ctl[k] = '0; m_pen[k] = 1'b0; m_pcfg[k] = '0; m_sts[k] = 1'b0;
    end
  endtask

  // one bus cycle: drive, predict, wait, compare
  task automatic cyc(string tag, bit wr, bit rd, logic [31:0] a, logic [31:0] d,
                     logic [N-1:0] ev);
    bit          hit;
    int          ch;
    logic [5:0]  off;
    logic [31:0] exp_rd;
    logic [N-1:0] exp_we;
    logic [3:0]  nx;
    bit          clr;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; ctr_event = ev;
    hit = (a[31:9] == '0);
    ch  = int'(a[8:6]);
    off = a[5:0];
    exp_rd = '0;
    if (rd && hit) begin
      if (off[5:4] == 2'b00 && off[1:0] == 2'b00) exp_rd = ctr_val(ch, off[3:2]);
      else if (off == 6'h10) exp_rd = {15'd0, m_sts[ch], 12'd0, m_ctl[ch]};
    end
    exp_we = (wr && hit && off[5:4] == 2'b00 && off[1:0] == 2'b00) ? N'(1) << ch : '0;
    for (int k = 0; k < N; k++) begin
      nx = m_ctl[k];
      if (m_pen[k]) nx[0] = 1'b1;
      nx = nx & ~m_pcfg[k];
      m_pen[k] = 1'b0; m_pcfg[k] = '0; clr = 1'b0;
      if (wr && hit && ch == k && off == 6'h10) begin
        nx = nx | (d[3:0] & 4'hE);
        m_pen[k] = d[0];
      end
      if (wr && hit && ch == k && off == 6'h14) begin
        if (d[0]) begin nx[0] = 1'b0; m_pcfg[k] = d[3:0] & 4'hE; end
        else nx = nx & ~d[3:0];
        clr = d[16];
      end
      m_ctl[k] = nx;
      m_sts[k] = ev[k] | (m_sts[k] & !clr);
    end
    @(posedge clk);
    #(CLK_NS/4);
    chk("R12", "rvalid", 32'(bus_rvalid), 32'(rd));
    if (rd) chk(tag, "rdata", bus_rdata, exp_rd);
    chk(tag, "ctr_we", 32'(ctr_we), 32'(exp_we));
    if (exp_we != '0) begin
      chk("R2", "ctr_reg", 32'(ctr_reg), 32'(off[3:2]));
      chk("R2", "ctr_wdata", ctr_wdata, d);
    end
    chk(tag, "ch_ctrl", ch_ctrl, pack_ctl());
    chk(tag, "irq_status", 32'(irq_status), 32'(pack_sts()));
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 1'b0, 32'h0, 32'h0, '0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_NS * 100000);
    fails++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11", "ch_ctrl", ch_ctrl, '0);
    chk("R11", "irq_status", 32'(irq_status), 32'h0);
    chk("R11", "rvalid", 32'(bus_rvalid), 32'h0);
    chk("R11", "ctr_we", 32'(ctr_we), 32'h0);

    // R4 set without enable, zeros keep value
    cyc("R4", 1, 0, 32'h010, 32'h0000_000E, '0);
    chk("R4", "ch0 flags", 32'(ch_ctrl[3:0]), 32'hE);
    cyc("R4", 1, 0, 32'h010, 32'h0000_0002, '0);
    chk("R4", "ch0 unchanged", 32'(ch_ctrl[3:0]), 32'hE);
    // R6 clear without enable
    cyc("R6", 1, 0, 32'h014, 32'h0000_0004, '0);
    chk("R6", "ch0 flags", 32'(ch_ctrl[3:0]), 32'hA);
    // R5 set with enable: config first, enable last
    cyc("R5", 1, 0, 32'h090, 32'h0000_0007, '0);
    chk("R5", "ch2 config first", 32'(ch_ctrl[11:8]), 32'h6);
    idle("R5", 1);
    chk("R5", "ch2 enable last", 32'(ch_ctrl[11:8]), 32'h7);
    // R8 read of the flags word
    cyc("R8", 0, 1, 32'h090, 32'h0, '0);
    chk("R8", "ch2 word", bus_rdata, 32'h0000_0007);
    // R7 clear with enable: enable first, config after
    cyc("R7", 1, 0, 32'h094, 32'h0000_0007, '0);
    chk("R7", "ch2 enable first", 32'(ch_ctrl[11:8]), 32'h6);
    idle("R7", 1);
    chk("R7", "ch2 config after", 32'(ch_ctrl[11:8]), 32'h0);
    // R10 status set, read, clear, event wins over clear
    cyc("R10", 0, 0, 32'h0, 32'h0, 8'h08);
    chk("R10", "ch3 status", 32'(irq_status), 32'h08);
    cyc("R8", 0, 1, 32'h0D0, 32'h0, '0);
    chk("R8", "ch3 word", bus_rdata, 32'h0001_0000);
    cyc("R10", 1, 0, 32'h0D4, 32'h0001_0000, 8'h08);
    chk("R10", "event wins", 32'(irq_status), 32'h08);
    cyc("R10", 1, 0, 32'h0D4, 32'h0001_0000, '0);
    chk("R10", "cleared", 32'(irq_status), 32'h00);
    // R2 counter write forwarding
    cyc("R2", 1, 0, 32'h044, 32'hDEAD_BEEF, '0);
    chk("R2", "strobe ch1", 32'(ctr_we), 32'h02);
    // R3 counter read
    cyc("R3", 0, 1, 32'h1C8, 32'h0, '0);
    chk("R3", "ch7 first match", bus_rdata, 32'hC0DE_0072);
    // R9 write-only and unmapped offsets
    cyc("R9", 0, 1, 32'h014, 32'h0, '0);
    chk("R9", "clear reg reads 0", bus_rdata, 32'h0);
    cyc("R9", 0, 1, 32'h020, 32'h0, '0);
    cyc("R9", 0, 1, 32'h011, 32'h0, '0);
    cyc("R9", 1, 0, 32'h018, 32'h0000_000F, '0);
    chk("R9", "ch0 after unmapped write", 32'(ch_ctrl[3:0]), 32'hA);
    // R1 out-of-range addresses
    cyc("R1", 1, 0, 32'h210, 32'h0000_000E, '0);
    chk("R1", "no flag change", ch_ctrl, 32'h0000_000A);
    cyc("R1", 1, 0, 32'h8000_0004, 32'h1234_5678, '0);
    chk("R1", "no strobe", 32'(ctr_we), 32'h0);
    cyc("R1", 0, 1, 32'h0000_1008, 32'h0, '0);
    chk("R1", "reads zero", bus_rdata, 32'h0);

    // random traffic: R4 R5 R6 R7 R8 R9 R10 R12
    for (int i = 0; i < 3000; i++) begin
      int          op;
      logic [31:0] a;
      logic [31:0] d;
      logic [N-1:0] ev;
      op = int'($urandom % 3);
      case ($urandom % 8)
        0: a = 32'h00; 1: a = 32'h04; 2: a = 32'h08; 3: a = 32'h0C;
        4, 5: a = 32'h10; 6: a = 32'h14; default: a = 32'h3C;
      endcase
      a = a | (32'($urandom % 8) << 6);
      if ($urandom % 16 == 0) a = a | (32'h200 << ($urandom % 20));
      d  = $urandom;
      ev = ($urandom % 8 == 0) ? N'($urandom) : '0;
      cyc("R4 R5 R6 R7 R10 random", op == 0, op == 1, a, d, ev);
    end
    idle("R12", 2);
    summary();
    $finish;
  end
endmodule